// File: doc/BRIEF.md
# Bridge-Steered PWM Generator with Fault Shutdown

This block produces a pulse-width-modulated waveform from a free-running period counter. The counter is built from a period field and a small prescale phase below it, so a single period lasts `(period_i + 1) * 2^PRE_W` clocks. The duty value has the combined width of both fields. The waveform is steered onto four pins, A, B, C and D. Four steerings are available: a single output, a complementary half-bridge pair, and a full bridge driven in either direction.

A fault input, with selectable polarity, passes through a two-flop synchronizer into a shutdown latch. While shutdown is active, every pin is held at a safe state. Pins A and C share one safe-state code and pins B and D share another. Each code selects drive low, drive high or release the pin by dropping its output enable. The shutdown status can clear in one of two ways. With automatic restart it clears as soon as the synchronised fault is gone. Otherwise it stays set until a software clear pulse arrives after the fault has ended.

The pins never resume in the middle of a period. The same rule applies to duty and steering changes: a new duty value or a new bridge direction takes effect only when the counter starts a new period.

Top module: `epwm_shutdown`

## Requirements
- R1: A period lasts `(period_i+1)*2^PRE_W` clocks and starts with count 0. The modulated signal is active from count 0 for `duty` clocks. A duty of 0 is never active, and a duty at or above the period length is active for the whole period.
- R2: `duty_i` and `mode_i` are captured only in the cycle where the count wraps to 0. A change made mid-period leaves the rest of that period unchanged. The first period after reset runs with duty 0 in single mode.
- R3: `pwm_o` bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. The steering codes are as follows. `mode_i`=00 gives single: A carries the signal and the other pins are low. 01 gives half-bridge: A carries the signal and B is its inverse, with C and D low. 10 gives full-bridge forward: A is high, D carries the signal, and B and C are low. 11 gives full-bridge reverse: C is high, B carries the signal, and A and D are low.
- R4: With `fault_pol_i`=1 a high `fault_i` is a fault; with 0, a low one is. `sd_active_o` rises on the third rising clock edge after the fault level is applied. It stays set while the fault persists.
- R5: While `sd_active_o` is 1, pins A and C follow `safe_ac_i` and pins B and D follow `safe_bd_i`. Code 00 drives low (enable 1, value 0). Code 01 drives high (enable 1, value 1). Codes 10 and 11 release the pin (enable 0, value 0).
- R6: With `auto_restart_i`=1, `sd_active_o` clears by itself on the third rising edge after the fault level is removed.
- R7: With `auto_restart_i`=0, `sd_active_o` stays set after the fault ends. It clears on an edge where `sd_clear_i` is 1 and the synchronised fault is inactive. A clear pulse while the fault is still present has no effect.
- R8: After `sd_active_o` clears, the pins keep their safe state until the next period starts. Normal output resumes in the first cycle with count 0.
- R9: During reset, `sd_active_o` is 0, all `pwm_o` bits are 0 and all `pwm_oe_o` bits are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_i | input | PER_W | Period field; the period lasts (period_i+1)*2^PRE_W clocks |
| duty_i | input | PER_W+PRE_W | Duty value, captured at each period start |
| mode_i | input | 2 | Steering select, captured at each period start |
| fault_i | input | 1 | Asynchronous fault input |
| fault_pol_i | input | 1 | 1: fault when high, 0: fault when low |
| auto_restart_i | input | 1 | 1: shutdown clears itself once the fault ends |
| sd_clear_i | input | 1 | Software clear of the shutdown status |
| safe_ac_i | input | 2 | Safe-state code for pins A and C |
| safe_bd_i | input | 2 | Safe-state code for pins B and D |
| pwm_o | output | 4 | Pin values {D,C,B,A} |
| pwm_oe_o | output | 4 | Pin output enables {D,C,B,A} |
| sd_active_o | output | 1 | Shutdown status |

## Verification
The bench builds the block with PER_W=3 and PRE_W=2. This gives eight period values and a 5-bit duty value, small enough to sweep every period value against every reachable duty value in all four steering codes. Every pin is compared cycle by cycle over a whole period, including the zero-duty and full-duty ends. The fault path is swept over both polarities and all sixteen pairs of safe-state codes. Because periods are short, each run also reaches the held-safe interval between a cleared status and the next period start, under both restart policies.

// File: rtl/epwm_pkg.sv
package epwm_pkg;

  typedef enum logic [1:0] {
    STEER_SINGLE = 2'b00,
    STEER_HALF   = 2'b01,
    STEER_FWD    = 2'b10,
    STEER_REV    = 2'b11
  } steer_e;

  localparam logic [1:0] SAFE_DRIVE_LOW  = 2'b00;
  localparam logic [1:0] SAFE_DRIVE_HIGH = 2'b01;

  localparam int PIN_COUNT = 4;

endpackage

// File: rtl/epwm_timebase.sv
module epwm_timebase
  import epwm_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int PRE_W = 2,
  localparam int CNT_W = PER_W + PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  steer_e           mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output steer_e           mode_o,
  output logic             active_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  steer_e           mode_q, mode_d;
  logic [CNT_W-1:0] last_cnt;
  logic             load_en;

  // Last count of a period: period field followed by an all-ones phase.
  assign last_cnt = {period_i, {PRE_W{1'b1}}};
  // Greater-or-equal recovers if the period is shortened mid-count.
  assign load_en  = (cnt_q >= last_cnt);

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    duty_d = duty_q;
    mode_d = mode_q;
    if (load_en) begin
      cnt_d  = '0;
      duty_d = duty_i;
      mode_d = mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
      mode_q <= STEER_SINGLE;
    end else begin
      cnt_q <= cnt_d;
      if (load_en) begin
        duty_q <= duty_d;
        mode_q <= mode_d;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign wrap_o   = load_en;
  assign mode_o   = mode_q;
  assign active_o = (cnt_q < duty_q);

endmodule

// File: rtl/epwm_fault.sv
module epwm_fault #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic fault_pol_i,
  input  logic auto_restart_i,
  input  logic sd_clear_i,
  input  logic wrap_i,
  output logic fault_act_o,
  output logic sd_active_o,
  output logic gated_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   fault_norm;
  logic                   fault_act;
  logic                   sd_q, sd_d;
  logic                   gated_q, gated_d;

  // Normalise polarity before synchronising so that a reset chain reads as "no fault".
  assign fault_norm = fault_pol_i ? fault_i : ~fault_i;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = fault_norm;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], fault_norm};
    end
  endgenerate

  assign fault_act = sync_q[SYNC_STAGES-1];

  always_comb begin
    sd_d = sd_q;
    if (fault_act) begin
      sd_d = 1'b1;
    end else if (auto_restart_i || sd_clear_i) begin
      sd_d = 1'b0;
    end
  end

  // Safe-state hold persists until the first period start after the status clears.
  assign gated_d = sd_d | (gated_q & ~wrap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      sd_q    <= 1'b0;
      gated_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      sd_q    <= sd_d;
      gated_q <= gated_d;
    end
  end

  assign fault_act_o = fault_act;
  assign sd_active_o = sd_q;
  assign gated_o     = gated_q;

endmodule

// File: rtl/epwm_steer.sv
module epwm_steer
  import epwm_pkg::*;
(
  input  steer_e                mode_i,
  input  logic                  active_i,
  input  logic                  gated_i,
  input  logic [1:0]            safe_ac_i,
  input  logic [1:0]            safe_bd_i,
  output logic [PIN_COUNT-1:0]  pin_val_o,
  output logic [PIN_COUNT-1:0]  pin_oe_o
);

  logic [PIN_COUNT-1:0] norm_val;

  // Bit order {D,C,B,A}.
  always_comb begin
    unique case (mode_i)
      STEER_SINGLE: norm_val = {1'b0, 1'b0, 1'b0, active_i};
      STEER_HALF:   norm_val = {1'b0, 1'b0, ~active_i, active_i};
      STEER_FWD:    norm_val = {active_i, 1'b0, 1'b0, 1'b1};
      STEER_REV:    norm_val = {1'b0, 1'b1, active_i, 1'b0};
      default:      norm_val = '0;
    endcase
  end

  generate
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
      logic [1:0] code;
      // Even pins (A, C) form one pair, odd pins (B, D) the other.
      assign code = ((i % 2) == 1) ? safe_bd_i : safe_ac_i;
      always_comb begin
        if (gated_i) begin
          pin_val_o[i] = (code == SAFE_DRIVE_HIGH);
          pin_oe_o[i]  = ~code[1];
        end else begin
          pin_val_o[i] = norm_val[i];
          pin_oe_o[i]  = 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/epwm_shutdown.sv
module epwm_shutdown
  import epwm_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int PRE_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PER_W-1:0]       period_i,
  input  logic [PER_W+PRE_W-1:0] duty_i,
  input  logic [1:0]             mode_i,
  input  logic                   fault_i,
  input  logic                   fault_pol_i,
  input  logic                   auto_restart_i,
  input  logic                   sd_clear_i,
  input  logic [1:0]             safe_ac_i,
  input  logic [1:0]             safe_bd_i,
  output logic [3:0]             pwm_o,
  output logic [3:0]             pwm_oe_o,
  output logic                   sd_active_o
);

  localparam int CNT_W = PER_W + PRE_W;

  logic             rst_meta_q, rst_int;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  steer_e           mode_q;
  logic             active;
  logic             fault_act;
  logic             gated;

  // Asynchronous assertion, release aligned to the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int    <= rst_meta_q;
    end
  end

  epwm_timebase #(.PER_W(PER_W), .PRE_W(PRE_W)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_int),
    .period_i (period_i),
    .duty_i   (duty_i),
    .mode_i   (steer_e'(mode_i)),
    .cnt_o    (cnt),
    .wrap_o   (wrap),
    .mode_o   (mode_q),
    .active_o (active)
  );

  epwm_fault #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
    .clk            (clk),
    .rst_n          (rst_int),
    .fault_i        (fault_i),
    .fault_pol_i    (fault_pol_i),
    .auto_restart_i (auto_restart_i),
    .sd_clear_i     (sd_clear_i),
    .wrap_i         (wrap),
    .fault_act_o    (fault_act),
    .sd_active_o    (sd_active_o),
    .gated_o        (gated)
  );

  epwm_steer u_steer (
    .mode_i    (mode_q),
    .active_i  (active),
    .gated_i   (gated),
    .safe_ac_i (safe_ac_i),
    .safe_bd_i (safe_bd_i),
    .pin_val_o (pwm_o),
    .pin_oe_o  (pwm_oe_o)
  );

endmodule

// File: rtl/epwm_shutdown_chk.sv
module epwm_shutdown_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       mode_q,
  input logic             gated,
  input logic             fault_act,
  input logic             auto_restart_i,
  input logic             sd_clear_i,
  input logic             sd_active_o,
  input logic [1:0]       safe_ac_i,
  input logic [1:0]       safe_bd_i,
  input logic [3:0]       pwm_o,
  input logic [3:0]       pwm_oe_o
);

  p_mode_at_wrap_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(mode_q) |-> (cnt == '0));

  p_half_complement_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!gated && mode_q == 2'b01) |-> (pwm_o[1] != pwm_o[0]));

  p_fault_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    fault_act |=> sd_active_o);

  p_safe_enables_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    sd_active_o |-> (pwm_oe_o == {~safe_bd_i[1], ~safe_ac_i[1], ~safe_bd_i[1], ~safe_ac_i[1]}));

  p_status_held_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (sd_active_o && !auto_restart_i && !sd_clear_i) |=> sd_active_o);

  p_resume_on_boundary_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(gated) |-> (cnt == '0));

endmodule

bind epwm_shutdown epwm_shutdown_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_ni         (rst_int),
  .cnt            (cnt),
  .mode_q         (mode_q),
  .gated          (gated),
  .fault_act      (fault_act),
  .auto_restart_i (auto_restart_i),
  .sd_clear_i     (sd_clear_i),
  .sd_active_o    (sd_active_o),
  .safe_ac_i      (safe_ac_i),
  .safe_bd_i      (safe_bd_i),
  .pwm_o          (pwm_o),
  .pwm_oe_o       (pwm_oe_o)
);

// File: tb/epwm_shutdown_bench.sv
`timescale 1ns/1ps
module epwm_shutdown_bench;

  localparam int PW = 3;
  localparam int PR = 2;
  localparam int CW = PW + PR;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] period_i;
  logic [CW-1:0] duty_i;
  logic [1:0]    mode_i;
  logic          fault_i, fault_pol_i, auto_restart_i, sd_clear_i;
  logic [1:0]    safe_ac_i, safe_bd_i;
  logic [3:0]    pwm_o, pwm_oe_o;
  logic          sd_active_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int ph = 0;
  int len = 4;

  always #10 clk = ~clk;

  epwm_shutdown #(.PER_W(PW), .PRE_W(PR), .SYNC_STAGES(2)) u_epwm_shutdown (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i), .mode_i(mode_i),
    .fault_i(fault_i), .fault_pol_i(fault_pol_i), .auto_restart_i(auto_restart_i),
    .sd_clear_i(sd_clear_i), .safe_ac_i(safe_ac_i), .safe_bd_i(safe_bd_i),
    .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .sd_active_o(sd_active_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ph = (ph + 1) % len;
  endtask

  // Reset, then return at the first cycle with count 0.
  task automatic start(input int p);
    period_i = p[PW-1:0];
    len = (p + 1) * (1 << PR);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ph = 0;
  endtask

  // Expected pins {D,C,B,A} for a steering code and signal level.
  function automatic logic [3:0] steer_exp(input int m, input bit a);
    case (m)
      0: return {1'b0, 1'b0, 1'b0, a};
      1: return {1'b0, 1'b0, ~a, a};
      2: return {a, 1'b0, 1'b0, 1'b1};
      default: return {1'b0, 1'b1, a, 1'b0};
    endcase
  endfunction

  // Expected {oe, val} under shutdown.
  function automatic logic [7:0] safe_exp(input logic [1:0] ac, input logic [1:0] bd);
    logic av, bv, ao, bo;
    av = (ac == 2'b01); bv = (bd == 2'b01);
    ao = ~ac[1];        bo = ~bd[1];
    return {bo, ao, bo, ao, bv, av, bv, av};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    period_i = '0; duty_i = '0; mode_i = 2'b00;
    fault_i = 1'b0; fault_pol_i = 1'b1; auto_restart_i = 1'b1; sd_clear_i = 1'b0;
    safe_ac_i = 2'b00; safe_bd_i = 2'b00;

    // R9: reset state
    repeat (2) @(negedge clk);
    check(pwm_o == 4'h0 && pwm_oe_o == 4'hF && !sd_active_o, "R9 reset state",
          {23'd0, sd_active_o, pwm_oe_o, pwm_o}, 32'h0F0);

    // R1, R2, R3: every period, every reachable duty, every steering code
    for (int p = 0; p < (1 << PW); p++) begin
      for (int m = 0; m < 4; m++) begin
        int dmax;
        dmax = (p + 1) * (1 << PR) + 1;
        if (dmax > (1 << CW) - 1) dmax = (1 << CW) - 1;
        for (int d = 0; d <= dmax; d++) begin
          bit ok1, ok2;
          logic [3:0] bad_act, bad_exp;
          mode_i = m[1:0];
          duty_i = d[CW-1:0];
          start(p);
          ok1 = 1'b1;
          for (int k = 0; k < len; k++) begin
            if (pwm_o != 4'h0 || pwm_oe_o != 4'hF) ok1 = 1'b0;
            tick();
          end
          check(ok1, "R2 first period idle", {28'd0, pwm_o}, 32'h0);
          ok2 = 1'b1; bad_act = '0; bad_exp = '0;
          for (int k = 0; k < len; k++) begin
            logic [3:0] e;
            e = steer_exp(m, k < d);
            if (ok2 && (pwm_o != e || pwm_oe_o != 4'hF)) begin
              ok2 = 1'b0; bad_act = pwm_o; bad_exp = e;
            end
            tick();
          end
          if (m == 0) check(ok2, "R1 duty window", {28'd0, bad_act}, {28'd0, bad_exp});
          else        check(ok2, "R3 steering",    {28'd0, bad_act}, {28'd0, bad_exp});
        end
      end
    end

    // R2: mid-period change of direction and duty
    begin
      bit okA, okB;
      mode_i = 2'b10; duty_i = 5'd3;
      start(1);
      repeat (len) tick();
      repeat (2) tick();
      mode_i = 2'b11; duty_i = 5'd6;
      okA = 1'b1;
      while (ph != 0) begin
        if (pwm_o != steer_exp(2, ph < 3)) okA = 1'b0;
        tick();
      end
      check(okA, "R2 old direction kept", {28'd0, pwm_o}, {28'd0, steer_exp(2, 1'b0)});
      okB = 1'b1;
      for (int k = 0; k < len; k++) begin
        if (pwm_o != steer_exp(3, k < 6)) okB = 1'b0;
        tick();
      end
      check(okB, "R2 new direction at boundary", {28'd0, pwm_o}, {28'd0, steer_exp(3, 1'b1)});
    end

    // R4, R5, R6, R8: both polarities, all safe-state pairs, automatic restart
    for (int pol = 0; pol < 2; pol++) begin
      for (int ac = 0; ac < 4; ac++) begin
        for (int bd = 0; bd < 4; bd++) begin
          logic [7:0] se;
          bit oks, okh;
          fault_pol_i = pol[0]; fault_i = ~pol[0];
          auto_restart_i = 1'b1; mode_i = 2'b01; duty_i = 5'd3;
          safe_ac_i = ac[1:0]; safe_bd_i = bd[1:0];
          se = safe_exp(ac[1:0], bd[1:0]);
          start(1);
          repeat (3) tick();
          fault_i = pol[0];
          tick(); tick();
          check(!sd_active_o, "R4 two-flop latency", {31'd0, sd_active_o}, 32'd0);
          tick();
          check(sd_active_o, "R4 status set", {31'd0, sd_active_o}, 32'd1);
          check({pwm_oe_o, pwm_o} == se, "R5 safe state", {24'd0, pwm_oe_o, pwm_o}, {24'd0, se});
          oks = 1'b1;
          for (int k = 0; k < 10; k++) begin
            tick();
            if (!sd_active_o || {pwm_oe_o, pwm_o} != se) oks = 1'b0;
          end
          check(oks, "R5 safe held during fault", {24'd0, pwm_oe_o, pwm_o}, {24'd0, se});
          fault_i = ~pol[0];
          tick(); tick();
          check(sd_active_o, "R6 status until sync clears", {31'd0, sd_active_o}, 32'd1);
          tick();
          check(!sd_active_o, "R6 auto restart", {31'd0, sd_active_o}, 32'd0);
          okh = 1'b1;
          while (ph != 0) begin
            if ({pwm_oe_o, pwm_o} != se) okh = 1'b0;
            tick();
          end
          check(okh, "R8 safe until period start", {24'd0, pwm_oe_o, pwm_o}, {24'd0, se});
          check(pwm_o == steer_exp(1, 1'b1) && pwm_oe_o == 4'hF, "R8 resume at count 0",
                {24'd0, pwm_oe_o, pwm_o}, {24'd0, 4'hF, steer_exp(1, 1'b1)});
        end
      end
    end

    // R7, R8: software restart
    begin
      logic [7:0] se;
      bit okh;
      fault_pol_i = 1'b1; fault_i = 1'b0; auto_restart_i = 1'b0;
      mode_i = 2'b00; duty_i = 5'd3; safe_ac_i = 2'b01; safe_bd_i = 2'b00;
      se = safe_exp(2'b01, 2'b00);
      start(1);
      repeat (3) tick();
      fault_i = 1'b1;
      repeat (3) tick();
      check(sd_active_o, "R7 status set", {31'd0, sd_active_o}, 32'd1);
      sd_clear_i = 1'b1; tick(); sd_clear_i = 1'b0;
      check(sd_active_o, "R7 clear ignored during fault", {31'd0, sd_active_o}, 32'd1);
      tick();
      fault_i = 1'b0;
      repeat (5) tick();
      check(sd_active_o, "R7 no self clear", {31'd0, sd_active_o}, 32'd1);
      check({pwm_oe_o, pwm_o} == se, "R7 pins safe while held", {24'd0, pwm_oe_o, pwm_o}, {24'd0, se});
      sd_clear_i = 1'b1; tick(); sd_clear_i = 1'b0;
      check(!sd_active_o, "R7 software clear", {31'd0, sd_active_o}, 32'd0);
      okh = 1'b1;
      while (ph != 0) begin
        if ({pwm_oe_o, pwm_o} != se) okh = 1'b0;
        tick();
      end
      check(okh, "R8 held after software clear", {24'd0, pwm_oe_o, pwm_o}, {24'd0, se});
      check(pwm_o == 4'b0001 && pwm_oe_o == 4'hF, "R8 resume after software clear",
            {24'd0, pwm_oe_o, pwm_o}, 32'hF1);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule